// File: doc/BRIEF.md
# Carrier Acquisition Frequency Sweep Controller

During initial acquisition a demodulator has to find the carrier before its tracking loop can lock. This block steps the carrier frequency word through a grid of frequencies that the host programs. The host sets a start frequency, a step size, a dwell time counted in symbol strobes, and the number of grid points to visit. The block holds each frequency for the dwell time. If lock does not come in that time, it moves to the next point. After the last point it returns to the start frequency and runs through the grid again.

The host watches the lock flag. Once lock is seen, the host clears the enable, and the frequency word then stays where the search found the carrier. The frequency word drives the carrier oscillator directly, and the host can also read it as a high-resolution estimate of the carrier frequency. The oscillator, the tracking loops and the lock detector lie outside this block.

Top module: `carrier_sweep_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `freq_word` becomes 0, the dwell count and the point index clear, and the sweep is idle.
- R2: At the first clock edge where `sweep_en` is sampled high after it was low (or after reset), `freq_word` loads `start_freq` and the point index clears. A symbol strobe or lock in that cycle is not counted.
- R3: With the sweep running and lock low, the frequency changes at the edge that samples the Nth `sym_stb` pulse since the last frequency change, where N is `dwell_len`. A `dwell_len` of 0 or 1 means a single strobe. Cycles without `sym_stb` do not count.
- R4: A step sets `freq_word` to the old word plus `step_size`, with `step_size` zero-extended to 20 bits and the sum taken modulo 2^20.
- R5: The start frequency counts as point 1. After `max_points` points have been visited, the next dwell expiry returns `freq_word` to `start_freq`, and the sweep repeats the same grid.
- R6: When `max_points` is 0 or 1, every dwell expiry reloads `start_freq`, so the word never leaves the start frequency.
- R7: Strobes that arrive while `lock` is high are not counted. The dwell count is held, and counting resumes from the held value when `lock` falls.
- R8: While `sweep_en` is low, `freq_word` holds its value and strobes are ignored. Raising the enable again restarts the sweep as in R2.
- R9: `start_freq` is sampled only at the enable edge and at each wrap. A change made during a sweep takes effect at the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sweep_en | input | 1 | Host enable for the sweep; low inhibits it |
| sym_stb | input | 1 | One-cycle pulse per symbol period |
| lock | input | 1 | Lock flag from the lock detector |
| start_freq | input | 20 | Start carrier frequency word |
| dwell_len | input | 16 | Dwell time per point, in symbol strobes |
| step_size | input | 16 | Frequency increment between points |
| max_points | input | 8 | Number of grid points per pass |
| freq_word | output | 20 | Current carrier frequency word |

## Verification
Directed sequences separate the main behaviours:
- A three-point grid with gaps between strobes shows that only strobes advance the dwell and that the word wraps after the last point.
- A start near the top of the range with a step that crosses 2^20 exposes a missing modulo or a sign-extended step.
- Grids of zero and one point tell the single-point rule apart from an off-by-one in the point count.
- Lock pulses placed mid-dwell, and an enable that drops and rises again, show whether the count is held or lost and whether a restart reloads the start.

Random segments then vary the dwell (including 0), the point count, the step, the strobe density, lock and enable. The output is compared every cycle against a bench reference model.

// File: rtl/carrier_sweep_pkg.sv
// Package: shared defaults and the action code that the sweep
// sequencer passes to the frequency accumulator.
package carrier_sweep_pkg;
    localparam int FREQ_W_DEF  = 20;
    localparam int STEP_W_DEF  = 16;
    localparam int DWELL_W_DEF = 16;
    localparam int PTS_W_DEF   = 8;

    // What the frequency register does on the next edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2,
        ACT_WRAP = 2'd3
    } sweep_act_e;
endpackage

// File: rtl/sweep_dwell_timer.sv
// Module: sweep_dwell_timer
// Counts qualified symbol strobes at the current grid point. The
// expire output fires in the cycle of the strobe that completes the
// dwell. Assumes count is already gated by enable and lock. A limit
// of 0 or 1 is treated as a single strobe.
module sweep_dwell_timer #(
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               count,
    input  logic [DWELL_W-1:0] dwell_len,
    output logic               expire
);
    localparam int EXT_W = DWELL_W + 1;

    logic [DWELL_W-1:0] cnt_q;
    logic [EXT_W-1:0]   cnt_inc;

    // Next count widened by one bit so the compare cannot overflow.
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
        expire  = count && (cnt_inc >= {1'b0, dwell_len});
    end

    // Count register: clear on load or expiry, step on a strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || expire) begin
            cnt_q <= '0;
        end else if (count) begin
            cnt_q <= cnt_inc[DWELL_W-1:0];
        end
    end

    // R3
    dwell_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));

    // R7
    dwell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/sweep_point_ctr.sv
// Module: sweep_point_ctr
// Tracks which grid point the sweep is on and flags the last point
// of the pass. Assumes advance fires only on a dwell expiry. A point
// limit of 0 or 1 makes every point the last.
module sweep_point_ctr #(
    parameter int PTS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [PTS_W-1:0] max_points,
    output logic             at_last
);
    localparam int EXT_W = PTS_W + 1;

    logic [PTS_W-1:0] pt_q;
    logic [EXT_W-1:0] pt_inc;

    // Last-point detection, widened against overflow.
    always_comb begin
        pt_inc  = {1'b0, pt_q} + EXT_W'(1);
        at_last = (max_points <= PTS_W'(1)) || (pt_inc >= {1'b0, max_points});
    end

    // Point index: clear on load, wrap at last point, else increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_q <= '0;
        end else if (clear) begin
            pt_q <= '0;
        end else if (advance) begin
            pt_q <= at_last ? '0 : pt_inc[PTS_W-1:0];
        end
    end

    // R5
    point_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && at_last && !clear) |=> (pt_q == '0));

    // R5
    point_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !at_last && !clear) |=> (pt_q == $past(pt_q) + PTS_W'(1)));
endmodule

// File: rtl/sweep_freq_acc.sv
// Module: sweep_freq_acc
// Holds the carrier frequency word. It loads the start value on
// LOAD or WRAP, adds the zero-extended step on STEP, and holds
// otherwise. The add wraps modulo 2^FREQ_W. A step wider than the
// word is truncated.
module sweep_freq_acc
    import carrier_sweep_pkg::*;
#(
    parameter int FREQ_W = 20,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sweep_act_e        act,
    input  logic [FREQ_W-1:0] start_freq,
    input  logic [STEP_W-1:0] step_size,
    output logic [FREQ_W-1:0] freq_q
);
    logic [FREQ_W-1:0] step_ext;

    // Fit the step to the word width; the parameters pick the variant.
    generate
        if (STEP_W < FREQ_W) begin : g_pad
            always_comb step_ext = {{(FREQ_W - STEP_W){1'b0}}, step_size};
        end else begin : g_trim
            always_comb step_ext = step_size[FREQ_W-1:0];
        end
    endgenerate

    // Frequency register update as directed by the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD, ACT_WRAP: freq_q <= start_freq;
                ACT_STEP:           freq_q <= freq_q + step_ext;
                default:            freq_q <= freq_q;
            endcase
        end
    end

    // R9
    freq_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_WRAP) |=> (freq_q == $past(start_freq)));
endmodule

// File: rtl/carrier_sweep_ctrl.sv
// Module: carrier_sweep_ctrl (top)
// Dwell-and-step carrier search. The block registers the enable to
// detect its rising edge and decodes one action per cycle from the
// enable, lock, dwell expiry and last-point flag. It assumes sym_stb
// is a single-cycle pulse and that the host clears sweep_en once lock
// is confirmed.
module carrier_sweep_ctrl
    import carrier_sweep_pkg::*;
#(
    parameter int FREQ_W  = FREQ_W_DEF,
    parameter int STEP_W  = STEP_W_DEF,
    parameter int DWELL_W = DWELL_W_DEF,
    parameter int PTS_W   = PTS_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sweep_en,
    input  logic               sym_stb,
    input  logic               lock,
    input  logic [FREQ_W-1:0]  start_freq,
    input  logic [DWELL_W-1:0] dwell_len,
    input  logic [STEP_W-1:0]  step_size,
    input  logic [PTS_W-1:0]   max_points,
    output logic [FREQ_W-1:0]  freq_word
);
    logic       en_q;
    logic       start_pulse;
    logic       running;
    logic       count_stb;
    logic       dwell_done;
    logic       last_point;
    sweep_act_e act;

    // Enable history, used to find the enable's rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= sweep_en;
    end

    // Qualifiers: start on the rising edge; count strobes only while running without lock.
    always_comb begin
        start_pulse = sweep_en && !en_q;
        running     = sweep_en && en_q;
        count_stb   = running && !lock && sym_stb;
    end

    // Action decode for the frequency register.
    always_comb begin
        if (start_pulse)     act = ACT_LOAD;
        else if (dwell_done) act = last_point ? ACT_WRAP : ACT_STEP;
        else                 act = ACT_HOLD;
    end

    sweep_dwell_timer #(.DWELL_W(DWELL_W)) u_dwell (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_pulse),
        .count     (count_stb),
        .dwell_len (dwell_len),
        .expire    (dwell_done)
    );

    sweep_point_ctr #(.PTS_W(PTS_W)) u_point (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start_pulse),
        .advance    (dwell_done),
        .max_points (max_points),
        .at_last    (last_point)
    );

    sweep_freq_acc #(.FREQ_W(FREQ_W), .STEP_W(STEP_W)) u_freq (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .start_freq (start_freq),
        .step_size  (step_size),
        .freq_q     (freq_word)
    );

    // R2
    enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && !en_q) |=> (freq_word == $past(start_freq)));

    // R8
    disabled_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sweep_en |=> $stable(freq_word));

    // R7
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && en_q && lock) |=> $stable(freq_word));

    // R4
    step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dwell_done && !last_point) |=>
        (freq_word == FREQ_W'($past(freq_word) + FREQ_W'($past(step_size)))));

    // R6
    single_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dwell_done && max_points <= PTS_W'(1)) |=> (freq_word == $past(start_freq)));
endmodule

// File: tb/tb_carrier_sweep_ctrl.sv
`timescale 1ns/1ps
module tb_carrier_sweep_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sweep_en = 1'b0;
    logic        sym_stb = 1'b0;
    logic        lock = 1'b0;
    logic [19:0] start_freq = '0;
    logic [15:0] dwell_len = '0;
    logic [15:0] step_size = '0;
    logic [7:0]  max_points = '0;
    logic [19:0] freq_word;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // Reference model state
    logic [19:0] m_freq;
    int          m_pt, m_dw;
    bit          m_enq;

    always #4 clk = ~clk;

    carrier_sweep_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sweep_en(sweep_en), .sym_stb(sym_stb),
        .lock(lock), .start_freq(start_freq), .dwell_len(dwell_len),
        .step_size(step_size), .max_points(max_points), .freq_word(freq_word)
    );

    function automatic logic [19:0] add_step(input logic [19:0] f, input logic [15:0] s);
        return f + {4'h0, s};
    endfunction

    function automatic bit dwell_over(input int dw, input logic [15:0] lim);
        return (dw + 1) >= int'(lim);
    endfunction

    function automatic bit last_pt(input int pt, input logic [7:0] mx);
        return (mx <= 1) || ((pt + 1) >= int'(mx));
    endfunction

    // Advance the model by one edge using the inputs present at that edge.
    task automatic model_edge();
        if (!rst_n) begin
            m_freq = '0; m_pt = 0; m_dw = 0; m_enq = 1'b0;
        end else begin
            if (sweep_en) begin
                if (!m_enq) begin
                    m_freq = start_freq; m_pt = 0; m_dw = 0;
                end else if (!lock && sym_stb) begin
                    if (dwell_over(m_dw, dwell_len)) begin
                        m_dw = 0;
                        if (last_pt(m_pt, max_points)) begin
                            m_freq = start_freq; m_pt = 0;
                        end else begin
                            m_freq = add_step(m_freq, step_size); m_pt++;
                        end
                    end else begin
                        m_dw++;
                    end
                end
            end
            m_enq = sweep_en;
        end
    endtask

    task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: freq_word actual %05h expected %05h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive inputs, take the edge, compare output to model.
    task automatic cyc(input bit e, input bit s, input bit l, input string tag);
        sweep_en = e; sym_stb = s; lock = l;
        @(posedge clk); #1;
        model_edge();
        check(tag, freq_word, m_freq);
    endtask

    task automatic cfg(input logic [19:0] sf, input logic [15:0] dl,
                       input logic [15:0] ss, input logic [7:0] mp);
        start_freq = sf; dwell_len = dl; step_size = ss; max_points = mp;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            misses++;
            $display("FAIL watchdog (all requirements): actual hung run, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        // R1: reset state
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, "R1");
        check("R1", freq_word, 20'h00000);
        rst_n = 1'b1;

        // R2/R3/R4/R5: three-point grid, dwell 3
        cfg(20'h12345, 16'd3, 16'h0100, 8'd3);
        cyc(1, 1, 0, "R2");
        check("R2", freq_word, 20'h12345);
        cyc(1, 1, 0, "R3"); cyc(1, 0, 0, "R3"); cyc(1, 0, 0, "R3"); cyc(1, 1, 0, "R3");
        check("R3", freq_word, 20'h12345);
        cyc(1, 1, 0, "R4");
        check("R4", freq_word, 20'h12445);
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, "R4");
        check("R4", freq_word, 20'h12545);
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, "R5");
        check("R5", freq_word, 20'h12345);
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, "R5");
        check("R5", freq_word, 20'h12445);

        // R4: modulo 2^20 wrap of the add
        cyc(0, 0, 0, "R8");
        cfg(20'hFFFF0, 16'd1, 16'h0020, 8'd4);
        cyc(1, 0, 0, "R2");
        cyc(1, 1, 0, "R4");
        check("R4", freq_word, 20'h00010);

        // R6: zero and one point grids stay at start
        cyc(0, 0, 0, "R8");
        cfg(20'hABCDE, 16'd1, 16'h0111, 8'd1);
        cyc(1, 0, 0, "R2");
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, "R6");
        check("R6", freq_word, 20'hABCDE);
        max_points = 8'd0;
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, "R6");
        check("R6", freq_word, 20'hABCDE);

        // R7: lock holds the dwell count
        cyc(0, 0, 0, "R8");
        cfg(20'h00000, 16'd2, 16'h0001, 8'd4);
        cyc(1, 0, 0, "R2");
        cyc(1, 1, 0, "R7");
        for (int i = 0; i < 5; i++) cyc(1, 1, 1, "R7");
        check("R7", freq_word, 20'h00000);
        cyc(1, 1, 0, "R7");
        check("R7", freq_word, 20'h00001);

        // R8: disable freezes, re-enable reloads start
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, "R8");
        check("R8", freq_word, 20'h00001);
        start_freq = 20'h00300;
        cyc(1, 1, 0, "R8");
        check("R8", freq_word, 20'h00300);

        // R9: start change during a sweep applies at the wrap; dwell 0 means one strobe
        cyc(0, 0, 0, "R8");
        cfg(20'h00100, 16'd0, 16'h0010, 8'd2);
        cyc(1, 0, 0, "R2");
        cyc(1, 1, 0, "R3");
        check("R3", freq_word, 20'h00110);
        start_freq = 20'h00200;
        check("R9", freq_word, 20'h00110);
        cyc(1, 1, 0, "R9");
        check("R9", freq_word, 20'h00200);

        // Random segments checked against the model
        for (int seg = 0; seg < 24; seg++) begin
            cfg(20'($urandom), 16'($urandom % 5), 16'($urandom), 8'($urandom % 7));
            for (int k = 0; k < 300; k++) begin
                cyc(($urandom % 40) != 0, $urandom % 2, ($urandom % 10) == 0, "R3 R4 R5 R7 rand");
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule